// File: doc/BRIEF.md
# Model-Specific Register Access Permission Checker

This block decides whether a guest read or write of a model-specific register must leave the guest. Each request carries a 32-bit register index, a direction bit (0 = read, 1 = write), the physical base address of a permission bitmap, and the enable bit of the register-access intercept. When the intercept is off, the answer is "no exit" at once. When it is on, the index is mapped into the bitmap, one byte is fetched through a single-byte request/response memory port, and the result reports whether the access must exit.

Three windows of register indices share the bitmap. Each window holds 8192 registers with two bits per register, so each fills 2048 bytes. The low window starts at index 0x0000_0000 and maps to bytes 0..2047. The window at 0xC000_0000 maps to bytes 2048..4095. The window at 0xC001_0000 maps to bytes 4096..6143. An index outside all three windows exits without any memory access. While a request is in flight, the block holds busy high and ignores new requests.

Top module: `msr_perm_check`

## Requirements
- R1: After reset, busy, done, mem_req and exit_take are all 0.
- R2: With intercept_en = 0, a request completes with exit_take = 0 and issues no memory request.
- R3: For an index n in 0x0000_0000..0x0000_1FFF, the block requests byte address bitmap_base + (2n)/8, and the tested bit is (2n mod 8) + rw.
- R4: For an index in 0xC000_0000..0xC000_1FFF, the slot is n = 8192 + (index − 0xC000_0000). The address and bit follow the R3 formula with this n.
- R5: For an index in 0xC001_0000..0xC001_1FFF, the slot is n = 16384 + (index − 0xC001_0000). The address and bit follow the R3 formula with this n.
- R6: An enabled request whose index lies outside all three windows completes with exit_take = 1 and issues no memory request.
- R7: Bit (2n mod 8) of the fetched byte gates reads and the bit above it gates writes. exit_take is 1 exactly when the gating bit is 1.
- R8: When done is high, exit_info equals the request's rw bit. exit_code equals EXIT_CODE (default 0x07C) when exit_take is 1 and 0 otherwise.
- R9: busy rises the cycle after a request is accepted in idle and stays high through the done cycle. A req_valid seen while busy is high, including during done, is ignored.
- R10: mem_req is a one-cycle pulse. mem_addr stays stable from that pulse until mem_rvalid. The result waits for mem_rvalid for any latency.
- R11: done is a one-cycle pulse per accepted request. exit_take is 0 whenever done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New check request; taken only when busy is low |
| req_index | input | 32 | Model-specific register index |
| req_write | input | 1 | Access direction: 0 read, 1 write |
| intercept_en | input | 1 | Register-access intercept enable |
| bitmap_base | input | ADDR_W | Physical base address of the permission bitmap |
| busy | output | 1 | A request is in flight |
| mem_req | output | 1 | Single-byte read request pulse |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_rdata | input | 8 | Returned byte |
| mem_rvalid | input | 1 | mem_rdata is valid |
| done | output | 1 | Result pulse |
| exit_take | output | 1 | Access must exit (qualified by done) |
| exit_info | output | 1 | Direction bit of the finished request |
| exit_code | output | CODE_W | Exit type code when exiting, else 0 |

## Verification
Two events can land in the same cycle: a new req_valid and the done pulse of the previous request. The bench raises req_valid exactly in the done cycle, and separately in the compute cycle right after acceptance. It then judges the outcome at the ports: busy must fall, and no further mem_req or done may follow. The first request's result must match the model computed for the original index, not the index that was poked in. A second coincidence is a long memory latency meeting a held address. The bench compares mem_addr against its first value on every cycle of the wait.

// File: rtl/msr_perm_pkg.sv
package msr_perm_pkg;

    localparam int IDX_W   = 32;
    localparam int NUM_WIN = 3;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_CALC = 3'd1,
        S_REQ  = 3'd2,
        S_WAIT = 3'd3,
        S_RESP = 3'd4
    } chk_state_e;

    // First index of each register window; window w fills bitmap slots
    // starting at w * 2**SPAN_LG.
    function automatic logic [IDX_W-1:0] win_start(input int w);
        case (w)
            0:       return 32'h0000_0000;
            1:       return 32'hC000_0000;
            default: return 32'hC001_0000;
        endcase
    endfunction

endpackage

// File: rtl/msr_window_map.sv
module msr_window_map #(
    parameter int ADDR_W  = 40,
    parameter int SPAN_LG = 13
) (
    input  logic [msr_perm_pkg::IDX_W-1:0] idx,
    output logic                           in_win,
    output logic [ADDR_W-1:0]              byte_off,
    output logic [2:0]                     bit_pos
);
    import msr_perm_pkg::*;

    localparam int SLOT_W = SPAN_LG + $clog2(NUM_WIN + 1);

    logic [NUM_WIN-1:0] hit;
    logic [SLOT_W-1:0]  slot_w [NUM_WIN];
    logic [SLOT_W-1:0]  slot;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [IDX_W-1:0]  START = win_start(w);
        localparam logic [SLOT_W-1:0] FIRST = SLOT_W'(w) << SPAN_LG;
        assign hit[w]    = (idx[IDX_W-1:SPAN_LG] == START[IDX_W-1:SPAN_LG]);
        assign slot_w[w] = hit[w]
                         ? (FIRST | SLOT_W'(idx[SPAN_LG-1:0]))
                         : '0;
    end

    always_comb begin
        slot = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            slot = slot | slot_w[w];
        end
    end

    // Two bits per slot: four slots share one byte.
    assign in_win   = |hit;
    assign byte_off = ADDR_W'(slot >> 2);
    assign bit_pos  = {slot[1:0], 1'b0};

endmodule

// File: rtl/msr_bit_test.sv
module msr_bit_test (
    input  logic [7:0] data,
    input  logic [2:0] pair_pos,
    input  logic       rw,
    output logic       hit
);
    logic [7:0] mask;

    always_comb begin
        mask = 8'(8'd1 << rw) << pair_pos;
        hit  = |(data & mask);
    end

endmodule

// File: rtl/msr_perm_check.sv
module msr_perm_check #(
    parameter int                ADDR_W    = 40,
    parameter int                SPAN_LG   = 13,
    parameter int                CODE_W    = 12,
    parameter logic [CODE_W-1:0] EXIT_CODE = 12'h07C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_index,
    input  logic              req_write,
    input  logic              intercept_en,
    input  logic [ADDR_W-1:0] bitmap_base,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_rvalid,
    output logic              done,
    output logic              exit_take,
    output logic              exit_info,
    output logic [CODE_W-1:0] exit_code
);
    import msr_perm_pkg::*;

    typedef struct packed {
        chk_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic              rw;
        logic              en;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        bp;
        logic              ex;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: S_IDLE, default: '0};

    ctl_t ctl_d, ctl_q;

    logic              in_win;
    logic [ADDR_W-1:0] byte_off;
    logic [2:0]        bit_pos;
    logic              bit_hit;

    msr_window_map #(
        .ADDR_W (ADDR_W),
        .SPAN_LG(SPAN_LG)
    ) u_map (
        .idx     (ctl_q.idx),
        .in_win  (in_win),
        .byte_off(byte_off),
        .bit_pos (bit_pos)
    );

    msr_bit_test u_test (
        .data    (mem_rdata),
        .pair_pos(ctl_q.bp),
        .rw      (ctl_q.rw),
        .hit     (bit_hit)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    ctl_d.idx  = req_index;
                    ctl_d.rw   = req_write;
                    ctl_d.en   = intercept_en;
                    ctl_d.base = bitmap_base;
                    ctl_d.ex   = 1'b0;
                    ctl_d.st   = S_CALC;
                end
            end
            S_CALC: begin
                if (!ctl_q.en) begin
                    ctl_d.ex = 1'b0;
                    ctl_d.st = S_RESP;
                end else if (!in_win) begin
                    ctl_d.ex = 1'b1;
                    ctl_d.st = S_RESP;
                end else begin
                    ctl_d.addr = ctl_q.base + byte_off;
                    ctl_d.bp   = bit_pos;
                    ctl_d.st   = S_REQ;
                end
            end
            S_REQ: begin
                ctl_d.st = S_WAIT;
            end
            S_WAIT: begin
                if (mem_rvalid) begin
                    ctl_d.ex = bit_hit;
                    ctl_d.st = S_RESP;
                end
            end
            S_RESP: begin
                ctl_d.st = S_IDLE;
            end
            default: begin
                ctl_d = CTL_RST;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy      = (ctl_q.st != S_IDLE);
    assign mem_req   = (ctl_q.st == S_REQ);
    assign mem_addr  = ctl_q.addr;
    assign done      = (ctl_q.st == S_RESP);
    assign exit_take = done & ctl_q.ex;
    assign exit_info = done & ctl_q.rw;
    assign exit_code = exit_take ? EXIT_CODE : '0;

endmodule

// File: rtl/msr_perm_check_sva.sv
module msr_perm_check_sva #(
    parameter int                ADDR_W    = 40,
    parameter int                CODE_W    = 12,
    parameter logic [CODE_W-1:0] EXIT_CODE = 12'h07C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              done,
    input logic              exit_take,
    input logic [CODE_W-1:0] exit_code
);
    logic waiting_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting_q <= 1'b0;
        end else if (mem_req) begin
            waiting_q <= 1'b1;
        end else if (mem_rvalid || !busy) begin
            waiting_q <= 1'b0;
        end
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    exit_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_take |-> done);

    // R10
    mem_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || (waiting_q && !mem_rvalid)) |=> $stable(mem_addr));

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R9
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R8
    code_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_take |-> (exit_code == EXIT_CODE));

endmodule

bind msr_perm_check msr_perm_check_sva #(
    .ADDR_W   (ADDR_W),
    .CODE_W   (CODE_W),
    .EXIT_CODE(EXIT_CODE)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rvalid(mem_rvalid),
    .done      (done),
    .exit_take (exit_take),
    .exit_code (exit_code)
);

// File: tb/msr_perm_check_test.sv
module msr_perm_check_test;
    localparam int          ADDR_W = 40;
    localparam int          CODE_W = 12;
    localparam logic [11:0] CODE   = 12'h07C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [31:0]       req_index = '0;
    logic              req_write = 1'b0;
    logic              intercept_en = 1'b0;
    logic [ADDR_W-1:0] bitmap_base = '0;
    logic              busy, mem_req, done, exit_take, exit_info;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_rdata = '0;
    logic              mem_rvalid = 1'b0;
    logic [CODE_W-1:0] exit_code;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    msr_perm_check uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
        .req_write(req_write), .intercept_en(intercept_en), .bitmap_base(bitmap_base),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_rvalid(mem_rvalid), .done(done), .exit_take(exit_take),
        .exit_info(exit_info), .exit_code(exit_code)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
        logic [7:0] p;
        p = a[7:0] * 8'd157;
        return p ^ a[15:8] ^ 8'h5A;
    endfunction

    // Independent model of the mapping (R3..R7)
    task automatic model(input logic [31:0] idx, input logic rw, input logic en,
                         input logic [ADDR_W-1:0] base, output bit use_mem,
                         output logic [ADDR_W-1:0] addr, output bit ex);
        longint unsigned n;
        longint unsigned bitnum;
        bit inw = 1'b1;
        logic [7:0] b;
        if (idx <= 32'h1FFF)                              n = idx;
        else if (idx >= 32'hC000_0000 && idx <= 32'hC000_1FFF) n = 8192 + (idx - 32'hC000_0000);
        else if (idx >= 32'hC001_0000 && idx <= 32'hC001_1FFF) n = 16384 + (idx - 32'hC001_0000);
        else begin n = 0; inw = 1'b0; end
        bitnum  = n * 2;
        addr    = base + ADDR_W'(bitnum / 8);
        use_mem = en && inw;
        if (!en) ex = 1'b0;
        else if (!inw) ex = 1'b1;
        else begin
            b  = mem_byte(addr);
            ex = b[(bitnum % 8) + rw];
        end
    endtask

    // One request; poke=1 raises req_valid in the compute cycle,
    // poke=2 raises it in the done cycle.
    task automatic run(input string tag, input logic [31:0] idx, input logic rw,
                       input logic en, input logic [ADDR_W-1:0] base,
                       input int lat, input int poke);
        bit use_mem, ex, seen, answered, got;
        logic [ADDR_W-1:0] ea, seen_addr;
        int nreq, cnt;
        model(idx, rw, en, base, use_mem, ea, ex);
        @(negedge clk);
        req_index = idx; req_write = rw; intercept_en = en; bitmap_base = base;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        seen = 0; answered = 0; got = 0; nreq = 0; cnt = 0; seen_addr = '0;
        for (int it = 0; it < 400; it++) begin
            if (poke == 1 && it == 0) begin
                chk(busy == 1'b1, "R9", "busy after accept", 64'(busy), 1);
                req_valid = 1'b1; req_index = 32'hFFFF_FFFF; req_write = ~rw;
            end else if (poke == 1 && it == 1) begin
                req_valid = 1'b0;
            end
            if (done) begin got = 1; break; end
            if (exit_take) chk(0, "R11", "exit_take without done", 1, 0);
            if (mem_rvalid) mem_rvalid = 1'b0;
            if (mem_req) begin
                nreq++; seen = 1; seen_addr = mem_addr; cnt = lat;
            end else if (seen && !answered) begin
                if (mem_addr != seen_addr)
                    chk(0, "R10", "mem_addr moved while waiting", 64'(mem_addr), 64'(seen_addr));
                if (cnt == 0) begin
                    mem_rvalid = 1'b1; mem_rdata = mem_byte(seen_addr); answered = 1;
                end else cnt--;
            end
            @(negedge clk);
        end
        chk(got, tag, "done seen", 64'(got), 1);
        chk(exit_take == ex, tag, "exit_take", 64'(exit_take), 64'(ex));
        chk(exit_info == rw, "R8", "exit_info", 64'(exit_info), 64'(rw));
        chk(exit_code == (ex ? CODE : 12'h0), "R8", "exit_code", 64'(exit_code),
            64'(ex ? CODE : 12'h0));
        chk(nreq == (use_mem ? 1 : 0), tag, "memory request count", 64'(nreq),
            64'(use_mem ? 1 : 0));
        if (use_mem)
            chk(seen_addr == ea, tag, "byte address", 64'(seen_addr), 64'(ea));
        if (poke == 2) req_valid = 1'b1;
        req_index = 32'hFFFF_FFFF;
        @(negedge clk);
        req_valid = 1'b0;
        chk(done == 1'b0, "R11", "done single pulse", 64'(done), 0);
        if (poke != 0) begin
            chk(busy == 1'b0, "R9", "idle after result", 64'(busy), 0);
            nreq = 0; got = 0;
            for (int k = 0; k < 6; k++) begin
                if (mem_req) nreq++;
                if (done || busy) got = 1;
                @(negedge clk);
            end
            chk(nreq == 0 && !got, "R9", "poked request ignored", 64'(got), 0);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req && !exit_take, "R1", "outputs in reset",
            {busy, done, mem_req, exit_take}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req, "R1", "outputs after reset",
            {busy, done, mem_req}, 0);
    endtask

    task automatic t_disabled();
        run("R2", 32'h0000_0010, 1'b0, 1'b0, 40'h10_0000_0000, 1, 0);
        run("R2", 32'hDEAD_BEEF, 1'b1, 1'b0, 40'h10_0000_0000, 1, 0);
    endtask

    task automatic t_low();
        for (int i = 0; i < 8; i++) begin
            run("R3", 32'(i), 1'b0, 1'b1, 40'h00_1234_5000, 0, 0);
            run("R7", 32'(i), 1'b1, 1'b1, 40'h00_1234_5000, 0, 0);
        end
        run("R3", 32'h0000_1FFF, 1'b1, 1'b1, 40'h00_1234_5000, 1, 0);
    endtask

    task automatic t_mid();
        run("R4", 32'hC000_0000, 1'b0, 1'b1, 40'h7F_0000_1000, 1, 0);
        run("R4", 32'hC000_0081, 1'b1, 1'b1, 40'h7F_0000_1000, 2, 0);
        run("R4", 32'hC000_1FFF, 1'b1, 1'b1, 40'h7F_0000_1000, 0, 0);
    endtask

    task automatic t_high();
        run("R5", 32'hC001_0000, 1'b0, 1'b1, 40'h00_0000_3000, 1, 0);
        run("R5", 32'hC001_0A53, 1'b1, 1'b1, 40'h00_0000_3000, 0, 0);
        run("R5", 32'hC001_1FFF, 1'b0, 1'b1, 40'h00_0000_3000, 3, 0);
    endtask

    task automatic t_outside();
        run("R6", 32'h0000_2000, 1'b0, 1'b1, 40'h0, 1, 0);
        run("R6", 32'hBFFF_FFFF, 1'b1, 1'b1, 40'h0, 1, 0);
        run("R6", 32'hC000_2000, 1'b0, 1'b1, 40'h0, 1, 0);
        run("R6", 32'hC001_2000, 1'b1, 1'b1, 40'h0, 1, 0);
        run("R6", 32'hFFFF_FFFF, 1'b0, 1'b1, 40'h0, 1, 0);
    endtask

    task automatic t_collide();
        run("R9", 32'h0000_0005, 1'b1, 1'b1, 40'h00_0000_8000, 2, 1);
        run("R9", 32'hC000_0007, 1'b0, 1'b1, 40'h00_0000_8000, 1, 2);
    endtask

    task automatic t_latency();
        run("R10", 32'h0000_0123, 1'b0, 1'b1, 40'h00_00AB_C000, 25, 0);
        run("R10", 32'hC001_0456, 1'b1, 1'b1, 40'h00_00AB_C000, 60, 0);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_low();
        t_mid();
        t_high();
        t_outside();
        t_collide();
        t_latency();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule